// File: doc/BRIEF.md
# Software-Managed Translation Buffer with Probe

This block is a fully associative address-translation buffer whose contents are maintained entirely by software. Software loads five staging registers (a virtual tag, an even frame word, an odd frame word, a page-size mask and a slot register) through a small write port. It then issues single-cycle commands that copy the staging registers into an entry, look for an entry that matches the virtual tag, or copy an entry back into the staging registers. Each entry maps one virtual page pair to two physical frames, one for the even page and one for the odd page.

There is no state machine. Each command completes in the clock edge on which its strobe is sampled. The command code selects one of four named actions:

- `OP_WR_INDEXED` (code 0) writes the entry named by the slot register.
- `OP_WR_RANDOM` (code 1) writes the entry named by an external random slot input.
- `OP_PROBE` (code 2) compares the tag against every entry in parallel.
- `OP_READ` (code 3) repacks an entry into the staging registers.

The transition is the same for every command: the strobe is sampled at one edge, and the result is visible on the staging outputs after that edge. The table is used by a processor's exception handlers to refill and inspect translations. Page-table walking, variable page-size matching and the translation lookup path are not part of this block.

Top module: `soft_tlb`

## Requirements
- R1: After reset all staging registers read zero and no entry can match, so a probe issued straight after reset sets bit 31 of the slot register.
- R2: When `st_wr_en` is high, `st_wr_sel` selects the register that takes `st_wr_data` on the next edge: 0 tag, 1 even frame word, 2 odd frame word, 3 mask, 4 slot. Codes 5 to 7 change nothing.
- R3: Command 0 stores the staging contents into entry (slot register modulo the entry count).
- R4: Command 1 stores the staging contents into entry (`rand_slot` modulo the entry count) and leaves the slot register unchanged.
- R5: An entry keeps tag bits 31:13 as its virtual page number and tag bits 7:0 as its address-space ID. Tag bits 12:8 are dropped.
- R6: Command 2 matches a written entry when its page number equals tag bits 31:13 and either its global bit is set or its address-space ID equals tag bits 7:0. On a hit the slot register becomes the entry number with all upper bits zero.
- R7: On a probe miss, bit 31 of the slot register is set and bits 30:0 keep their value.
- R8: Command 3 loads the tag register with {page number, five zero bits, address-space ID} and loads the mask register with the stored mask. Each frame word is rebuilt as {6 zero bits, frame bits 25:6 as written, attribute 5:3, dirty 2, valid 1, global 0}.
- R9: The entry's global bit is bit 0 of the even word AND bit 0 of the odd word. An entry with only one half global matches only its own address-space ID.
- R10: When several entries match a probe, the lowest entry number is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_wr_en | input | 1 | Staging register write strobe |
| st_wr_sel | input | 3 | Staging register select |
| st_wr_data | input | 32 | Staging register write data |
| cmd_go | input | 1 | Single-cycle command strobe |
| cmd_op | input | 2 | Command code |
| rand_slot | input | 4 | Entry number for random write |
| vtag_q | output | 32 | Virtual tag staging register |
| lo_even_q | output | 32 | Even frame staging register |
| lo_odd_q | output | 32 | Odd frame staging register |
| mask_q | output | 32 | Page mask staging register |
| slot_q | output | 32 | Slot staging register |

## Verification
The assertions check the following on every cycle:
- A hit clears bit 31 of the slot register.
- A miss sets bit 31 and keeps the other slot bits.
- A read leaves tag bits 12:8 at zero.
- A written entry becomes live.
- Entry state and staging state hold when no command or write is present.
- The reported hit is the lowest set bit of the match vector.

Only the bench scenarios can show that the correct entry is addressed under the modulo rules. They also show that a half-global entry rejects a foreign address-space ID, and that read-back drops the top frame bits exactly as a reference model predicts.

// File: rtl/soft_tlb_pkg.sv
package soft_tlb_pkg;

    localparam int XLEN      = 32;
    localparam int ASID_W    = 8;
    localparam int PAGE_LSB  = 13;
    localparam int VPN_W     = XLEN - PAGE_LSB;
    localparam int FRAME_LSB = 6;
    localparam int FRAME_W   = XLEN - 12;
    localparam int PAD_W     = XLEN - FRAME_W - FRAME_LSB;
    localparam int ATTR_LSB  = 3;
    localparam int ATTR_W    = 3;

    typedef enum logic [1:0] {
        OP_WR_INDEXED = 2'd0,
        OP_WR_RANDOM  = 2'd1,
        OP_PROBE      = 2'd2,
        OP_READ       = 2'd3
    } tlb_op_e;

    typedef enum logic [2:0] {
        SEL_TAG  = 3'd0,
        SEL_EVEN = 3'd1,
        SEL_ODD  = 3'd2,
        SEL_MASK = 3'd3,
        SEL_SLOT = 3'd4
    } stage_sel_e;

    typedef struct packed {
        logic               valid;
        logic               dirty;
        logic [ATTR_W-1:0]  attr;
        logic [FRAME_W-1:0] frame;
    } half_t;

    typedef struct packed {
        logic              live;
        logic              glob;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [XLEN-1:0]   mask;
        half_t             even;
        half_t             odd;
    } entry_t;

    function automatic half_t unpack_half(input logic [XLEN-1:0] lo);
        half_t h;
        h.valid = lo[1];
        h.dirty = lo[2];
        h.attr  = lo[ATTR_LSB +: ATTR_W];
        h.frame = lo[FRAME_LSB +: FRAME_W];
        return h;
    endfunction

    function automatic logic [XLEN-1:0] pack_half(input half_t h, input logic g);
        return {{PAD_W{1'b0}}, h.frame, h.attr, h.dirty, h.valid, g};
    endfunction

endpackage

// File: rtl/soft_tlb_first.sv
module soft_tlb_first
    import soft_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_ENT-1:0] hit_vec,
    output logic             hit_any,
    output logic [IDX_W-1:0] first_idx
);

    always_comb begin
        hit_any   = 1'b0;
        first_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any   = 1'b1;
                first_idx = IDX_W'(i);
            end
        end
    end

    // R10: the reported entry matches and no lower entry matches
    assert_lowest_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (hit_vec[first_idx] &&
                     ((hit_vec & ((N_ENT'(1) << first_idx) - N_ENT'(1))) == '0)));

endmodule

// File: rtl/soft_tlb_entries.sv
module soft_tlb_entries
    import soft_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  entry_t            wr_entry,
    input  logic [IDX_W-1:0]  rd_idx,
    output entry_t            rd_entry,
    input  logic [VPN_W-1:0]  cmp_vpn,
    input  logic [ASID_W-1:0] cmp_asid,
    output logic [N_ENT-1:0]  hit_vec
);

    entry_t           ents [N_ENT];
    logic [N_ENT-1:0] live_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) ents[i] <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (wr_idx == IDX_W'(i)) ents[i] <= wr_entry;
            end
        end
    end

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
            assign live_vec[g] = ents[g].live;
            assign hit_vec[g]  = ents[g].live && (ents[g].vpn == cmp_vpn) &&
                                 (ents[g].glob || (ents[g].asid == cmp_asid));
        end
    endgenerate

    assign rd_entry = ents[rd_idx];

    // R3: a written entry is live on the next cycle
    assert_write_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> live_vec[$past(wr_idx)]);

    // R4: without a write strobe no entry changes liveness
    assert_hold_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(live_vec));

endmodule

// File: rtl/soft_tlb.sv
module soft_tlb
    import soft_tlb_pkg::*;
#(
    parameter int N_ENT = 16,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_wr_en,
    input  logic [2:0]       st_wr_sel,
    input  logic [XLEN-1:0]  st_wr_data,
    input  logic             cmd_go,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] rand_slot,
    output logic [XLEN-1:0]  vtag_q,
    output logic [XLEN-1:0]  lo_even_q,
    output logic [XLEN-1:0]  lo_odd_q,
    output logic [XLEN-1:0]  mask_q,
    output logic [XLEN-1:0]  slot_q
);

    localparam logic [XLEN-1:0] N_L     = XLEN'(N_ENT);
    localparam logic [XLEN-1:0] MISS_FL = XLEN'(1) << (XLEN - 1);

    tlb_op_e          op;
    logic             wr_en;
    logic [IDX_W-1:0] slot_idx;
    logic [IDX_W-1:0] rnd_idx;
    logic [IDX_W-1:0] wr_idx;
    entry_t           wr_entry;
    entry_t           rd_entry;
    logic [N_ENT-1:0] hit_vec;
    logic             hit_any;
    logic [IDX_W-1:0] first_idx;

    assign op       = tlb_op_e'(cmd_op);
    assign slot_idx = IDX_W'(slot_q % N_L);
    assign rnd_idx  = IDX_W'(XLEN'(rand_slot) % N_L);

    always_comb begin
        wr_en  = 1'b0;
        wr_idx = slot_idx;
        if (cmd_go) begin
            unique case (op)
                OP_WR_INDEXED: begin wr_en = 1'b1; wr_idx = slot_idx; end
                OP_WR_RANDOM:  begin wr_en = 1'b1; wr_idx = rnd_idx;  end
                OP_PROBE:      wr_en = 1'b0;
                OP_READ:       wr_en = 1'b0;
            endcase
        end
    end

    always_comb begin
        wr_entry.live = 1'b1;
        wr_entry.glob = lo_even_q[0] & lo_odd_q[0];
        wr_entry.vpn  = vtag_q[XLEN-1:PAGE_LSB];
        wr_entry.asid = vtag_q[ASID_W-1:0];
        wr_entry.mask = mask_q;
        wr_entry.even = unpack_half(lo_even_q);
        wr_entry.odd  = unpack_half(lo_odd_q);
    end

    soft_tlb_entries #(.N_ENT(N_ENT)) u_entries (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .rd_idx   (slot_idx),
        .rd_entry (rd_entry),
        .cmp_vpn  (vtag_q[XLEN-1:PAGE_LSB]),
        .cmp_asid (vtag_q[ASID_W-1:0]),
        .hit_vec  (hit_vec)
    );

    soft_tlb_first #(.N_ENT(N_ENT)) u_first (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec   (hit_vec),
        .hit_any   (hit_any),
        .first_idx (first_idx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vtag_q    <= '0;
            lo_even_q <= '0;
            lo_odd_q  <= '0;
            mask_q    <= '0;
            slot_q    <= '0;
        end else begin
            if (st_wr_en) begin
                case (st_wr_sel)
                    SEL_TAG:  vtag_q    <= st_wr_data;
                    SEL_EVEN: lo_even_q <= st_wr_data;
                    SEL_ODD:  lo_odd_q  <= st_wr_data;
                    SEL_MASK: mask_q    <= st_wr_data;
                    SEL_SLOT: slot_q    <= st_wr_data;
                    default:  ;
                endcase
            end
            if (cmd_go) begin
                unique case (op)
                    OP_WR_INDEXED, OP_WR_RANDOM: ;
                    OP_PROBE: slot_q <= hit_any ? XLEN'(first_idx) : (slot_q | MISS_FL);
                    OP_READ: begin
                        vtag_q    <= {rd_entry.vpn, {(PAGE_LSB-ASID_W){1'b0}}, rd_entry.asid};
                        mask_q    <= rd_entry.mask;
                        lo_even_q <= pack_half(rd_entry.even, rd_entry.glob);
                        lo_odd_q  <= pack_half(rd_entry.odd, rd_entry.glob);
                    end
                endcase
            end
        end
    end

    // R6: a hit leaves the miss flag clear
    assert_probe_hit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_PROBE && hit_any) |=> !slot_q[XLEN-1]);

    // R7: a miss raises the flag and keeps the remaining slot bits
    assert_probe_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_PROBE && !hit_any) |=>
            (slot_q[XLEN-1] && slot_q[XLEN-2:0] == $past(slot_q[XLEN-2:0])));

    // R8: read-back leaves the gap between page number and ID at zero
    assert_read_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_go && op == OP_READ) |=> (vtag_q[PAGE_LSB-1:ASID_W] == '0));

    // R2: staging holds when neither a write nor a command is present
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_go && !st_wr_en) |=> ($stable(slot_q) && $stable(vtag_q) &&
                                    $stable(lo_even_q) && $stable(lo_odd_q) && $stable(mask_q)));

endmodule

// File: tb/soft_tlb_bench.sv
`timescale 1ns/1ps
module soft_tlb_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_wr_en = 1'b0;
    logic [2:0]  st_wr_sel = '0;
    logic [31:0] st_wr_data = '0;
    logic        cmd_go = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  rand_slot = '0;
    logic [31:0] vtag_q, lo_even_q, lo_odd_q, mask_q, slot_q;

    always #4 clk = ~clk;

    soft_tlb #(.N_ENT(N)) u_soft_tlb (
        .clk(clk), .rst_n(rst_n), .st_wr_en(st_wr_en), .st_wr_sel(st_wr_sel),
        .st_wr_data(st_wr_data), .cmd_go(cmd_go), .cmd_op(cmd_op), .rand_slot(rand_slot),
        .vtag_q(vtag_q), .lo_even_q(lo_even_q), .lo_odd_q(lo_odd_q),
        .mask_q(mask_q), .slot_q(slot_q)
    );

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_hi [N];
    logic [31:0] m_mask [N];
    logic [31:0] m_lo_e [N];
    logic [31:0] m_lo_o [N];
    bit          m_g [N];
    bit          m_live [N];
    logic [31:0] s_hi = 0, s_e = 0, s_o = 0, s_mask = 0, s_slot = 0;

    function automatic logic [31:0] f_lo(input logic [31:0] lo, input bit g);
        return {6'b0, lo[25:6], lo[5:1], g};
    endfunction

    function automatic logic [31:0] f_probe(input logic [31:0] tag, input logic [31:0] cur);
        for (int i = 0; i < N; i++) begin
            if (m_live[i] && m_hi[i][31:13] == tag[31:13] &&
                (m_g[i] || m_hi[i][7:0] == tag[7:0])) return 32'(i);
        end
        return cur | 32'h8000_0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        check({req, " tag"},  vtag_q,    s_hi);
        check({req, " even"}, lo_even_q, s_e);
        check({req, " odd"},  lo_odd_q,  s_o);
        check({req, " mask"}, mask_q,    s_mask);
        check({req, " slot"}, slot_q,    s_slot);
    endtask

    task automatic stage(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        st_wr_en = 1'b1; st_wr_sel = sel; st_wr_data = d;
        @(negedge clk);
        st_wr_en = 1'b0;
        case (sel)
            3'd0: s_hi = d;
            3'd1: s_e = d;
            3'd2: s_o = d;
            3'd3: s_mask = d;
            3'd4: s_slot = d;
            default: ;
        endcase
    endtask

    task automatic command(input logic [1:0] op, input logic [3:0] rs);
        int idx;
        bit g;
        @(negedge clk);
        cmd_go = 1'b1; cmd_op = op; rand_slot = rs;
        @(negedge clk);
        cmd_go = 1'b0;
        if (op == 2'd0 || op == 2'd1) begin
            idx = (op == 2'd0) ? int'(s_slot % N) : int'(rs) % N;
            g = s_e[0] & s_o[0];
            m_hi[idx]   = {s_hi[31:13], 5'b0, s_hi[7:0]};
            m_mask[idx] = s_mask;
            m_g[idx]    = g;
            m_lo_e[idx] = f_lo(s_e, g);
            m_lo_o[idx] = f_lo(s_o, g);
            m_live[idx] = 1'b1;
        end else if (op == 2'd2) begin
            s_slot = f_probe(s_hi, s_slot);
        end else begin
            idx = int'(s_slot % N);
            s_hi = m_hi[idx]; s_mask = m_mask[idx];
            s_e = m_lo_e[idx]; s_o = m_lo_o[idx];
        end
    endtask

    task automatic put_entry(input int slot, input logic [31:0] hi,
                             input logic [31:0] e, input logic [31:0] o);
        stage(3'd0, hi); stage(3'd1, e); stage(3'd2, o);
        stage(3'd3, 32'h0000_6000 + 32'(slot));
        stage(3'd4, 32'(slot));
        command(2'd0, 4'd0);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [31:0] r;
        for (int i = 0; i < N; i++) begin
            m_hi[i] = 0; m_mask[i] = 0; m_lo_e[i] = 0; m_lo_o[i] = 0;
            m_g[i] = 0; m_live[i] = 0;
        end
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check_all("R1 reset");
        command(2'd2, 4'd0);
        check("R1 probe after reset", slot_q, 32'h8000_0000);

        stage(3'd5, 32'hFFFF_FFFF);
        stage(3'd7, 32'hA5A5_A5A5);
        check_all("R2 unused select");
        stage(3'd3, 32'h0001_E000);
        check("R2 mask load", mask_q, 32'h0001_E000);

        stage(3'd0, 32'h1234_5F42);
        stage(3'd1, 32'hFFFF_FFFF);
        stage(3'd2, 32'h0000_0FC3);
        stage(3'd4, 32'h0000_0013);
        command(2'd0, 4'd0);
        stage(3'd4, 32'd3);
        stage(3'd0, 0); stage(3'd1, 0); stage(3'd2, 0);
        command(2'd3, 4'd0);
        check_all("R3 R5 R8 wrap write and read back");
        check("R8 even repack", lo_even_q, 32'h03FF_FFFF);

        s_slot = 32'h0000_0007;
        stage(3'd4, 32'h0000_0007);
        stage(3'd0, 32'h0ABC_0011); stage(3'd1, 32'h0000_0047); stage(3'd2, 32'h0000_0086);
        command(2'd1, 4'd14);
        check("R4 slot kept", slot_q, 32'h0000_0007);
        stage(3'd4, 32'd14);
        command(2'd3, 4'd0);
        check_all("R4 random target read");

        put_entry(5, 32'h0000_A011, 32'h0000_0041, 32'h0000_0040);
        stage(3'd0, 32'h0000_A022);
        command(2'd2, 4'd0);
        check("R9 half global miss", slot_q, 32'h8000_0005);
        put_entry(6, 32'h0000_C011, 32'h0000_0041, 32'h0000_0081);
        stage(3'd0, 32'h0000_C033);
        command(2'd2, 4'd0);
        check("R9 R6 global hit", slot_q, 32'd6);

        put_entry(12, 32'h0004_0044, 32'h2, 32'h2);
        put_entry(9,  32'h0004_0044, 32'h4, 32'h4);
        stage(3'd0, 32'h0004_1F44);
        command(2'd2, 4'd0);
        check("R10 lowest match", slot_q, 32'd9);

        stage(3'd4, 32'h1234_5005);
        stage(3'd0, 32'h7777_0001);
        command(2'd2, 4'd0);
        check("R7 miss keeps bits", slot_q, 32'h9234_5005);

        for (int it = 0; it < 300; it++) begin
            r = $urandom % 9;
            case (r)
                0: stage(3'd0, {($urandom % 4) << 13} | 32'($urandom % 3 + 1) |
                               (32'($urandom % 32) << 8) | ($urandom & 32'hFFF8_0000));
                1: stage(3'd1, $urandom);
                2: stage(3'd2, $urandom);
                3: stage(3'd3, $urandom);
                4: stage(3'd4, ($urandom % 2) ? 32'($urandom % 64) : $urandom);
                5: command(2'd0, 4'd0);
                6: command(2'd1, 4'($urandom));
                7: command(2'd2, 4'd0);
                default: command(2'd3, 4'd0);
            endcase
            check_all("R3 R4 R5 R6 R8 random mix");
        end

        finish_run();
    end

endmodule